// File: doc/BRIEF.md
# Saturating Fractional Multiply-Accumulate Unit

This block multiplies two signed 16-bit fractions (Q0.15, range [-1, 1)) and adds the result into a 32-bit fractional accumulator (Q0.31). The full signed product is shifted left by one bit so that it lines up with the accumulator's binary point. The sum is then clamped to the nearest representable value instead of wrapping. The accumulator and all operands share one format, so successive operations need no rescaling.

A caller presents an operand pair together with a valid strobe. The unit can run with one or two stages, selected by a parameter; in both variants it accepts one new pair every cycle. A clear input loads the accumulator with a supplied value, which may be zero. The current accumulator is always visible, together with a rounded 16-bit view of it and a sticky flag that records any clamping.

Top module: `frac_mac_sat`

## Requirements
- R1: After reset, `acc` is 0x00000000, `res_q15` is 0x0000 and `sat` is 0.
- R2: Each product is the signed 32-bit product of `op_a` and `op_b` shifted left by one bit. For example, 0x4000 x 0x4000 adds 0x20000000.
- R3: When no overflow occurs, an accepted operation leaves `acc` equal to its previous value plus the aligned product, exactly.
- R4: An addition that overflows upward gives 0x7FFFFFFF, and one that overflows downward gives 0x80000000. It never wraps.
- R5: `sat` becomes 1 when any addition or product is clamped. It stays 1 until a clear.
- R6: The operand pair 0x8000 x 0x8000 gives the aligned product 0x7FFFFFFF and sets `sat`.
- R7: `res_q15` is `acc[31:16]` plus `acc[15]` (round half up). It becomes 0x7FFF when `acc[31:16]` is 0x7FFF and `acc[15]` is 1, and it follows `acc` in the same cycle.
- R8: `clr` loads `clr_val` into `acc` and clears `sat`. It overrides a strobe in the same cycle and, with PIPE=1, also drops the operation still in flight.
- R9: With PIPE=1, `acc` changes at the rising edge after the one that samples `vld`. With PIPE=0, it changes at the sampling edge.
- R10: Strobes on consecutive cycles are all accumulated, none lost.
- R11: If no operation completes and `clr` is low, `acc` and `sat` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Load `clr_val` into the accumulator and clear `sat` |
| clr_val | input | 32 | Q0.31 value loaded by `clr` |
| vld | input | 1 | Operand pair strobe |
| op_a | input | 16 | Q0.15 multiplicand |
| op_b | input | 16 | Q0.15 multiplier |
| acc | output | 32 | Q0.31 accumulator |
| res_q15 | output | 16 | Rounded Q0.15 view of `acc` |
| sat | output | 1 | Sticky clamp flag |

## Verification
With the default PIPE=1, a strobe sampled at edge k reaches `acc` and `sat` at edge k+1. A clear takes effect at the edge that samples it. `res_q15` is combinational from `acc`, so it is due in the same cycle as `acc`. The bench drives inputs on the falling edge and updates its model right after each rising edge, using a one-deep model pipeline with the same latency rule. It compares all three outputs at the following falling edge. A directed sequence checks that `acc` is still unchanged one edge after a strobe and has changed one edge later.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;
    localparam int OP_W  = 16;
    localparam int ACC_W = 2 * OP_W;

    typedef logic signed [OP_W-1:0]  op_t;
    typedef logic signed [ACC_W-1:0] acc_t;

    localparam acc_t ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam acc_t ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
    localparam op_t  OP_MIN  = {1'b1, {(OP_W-1){1'b0}}};
    localparam op_t  OP_MAX  = {1'b0, {(OP_W-1){1'b1}}};

    typedef struct packed {
        acc_t acc;
        logic sat;
        logic pv;
        acc_t pp;
        logic povf;
    } mac_state_t;
endpackage

// File: rtl/frac_mul_norm.sv
module frac_mul_norm
    import frac_mac_pkg::*;
(
    input  op_t  a,
    input  op_t  b,
    output acc_t prod,
    output logic ovf
);
    logic signed [2*OP_W-1:0] full;

    always_comb begin
        full = a * b;
        if (a == OP_MIN && b == OP_MIN) begin
            prod = ACC_MAX;
            ovf  = 1'b1;
        end else begin
            prod = {full[2*OP_W-2:0], 1'b0};
            ovf  = 1'b0;
        end
    end

    // R2: an aligned product that was not clamped always has a zero LSB
    always_comb begin
        if (!$isunknown({a, b}))
            p_even_lsb_r2: assert (ovf || prod[0] == 1'b0);
    end
endmodule

// File: rtl/frac_sat_add.sv
module frac_sat_add
    import frac_mac_pkg::*;
(
    input  acc_t x,
    input  acc_t y,
    output acc_t sum,
    output logic ovf
);
    logic signed [ACC_W:0] wide;

    always_comb begin
        wide = {x[ACC_W-1], x} + {y[ACC_W-1], y};
        ovf  = wide[ACC_W] ^ wide[ACC_W-1];
        if (ovf)
            sum = wide[ACC_W] ? ACC_MIN : ACC_MAX;
        else
            sum = wide[ACC_W-1:0];
    end
endmodule

// File: rtl/frac_round_q15.sv
module frac_round_q15
    import frac_mac_pkg::*;
(
    input  acc_t acc,
    output op_t  q
);
    op_t upper;

    always_comb begin
        upper = acc[ACC_W-1 -: OP_W];
        if (acc[OP_W-1] && upper == OP_MAX)
            q = OP_MAX;
        else
            q = upper + op_t'(acc[OP_W-1]);
    end
endmodule

// File: rtl/frac_mac_sat.sv
module frac_mac_sat
    import frac_mac_pkg::*;
#(
    parameter int PIPE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [ACC_W-1:0]  clr_val,
    input  logic              vld,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic [ACC_W-1:0]  acc,
    output logic [OP_W-1:0]   res_q15,
    output logic              sat
);
    mac_state_t st_d, st_q;

    acc_t mul_prod;
    logic mul_ovf;
    acc_t addend;
    logic add_en;
    logic add_povf;
    acc_t sum;
    logic sum_ovf;
    op_t  rnd;

    frac_mul_norm u_mul (
        .a    (op_t'(op_a)),
        .b    (op_t'(op_b)),
        .prod (mul_prod),
        .ovf  (mul_ovf)
    );

    generate
        if (PIPE != 0) begin : g_two_stage
            assign add_en   = st_q.pv;
            assign addend   = st_q.pp;
            assign add_povf = st_q.povf;
        end else begin : g_one_stage
            assign add_en   = vld;
            assign addend   = mul_prod;
            assign add_povf = mul_ovf;
        end
    endgenerate

    frac_sat_add u_add (
        .x   (st_q.acc),
        .y   (addend),
        .sum (sum),
        .ovf (sum_ovf)
    );

    frac_round_q15 u_rnd (
        .acc (st_q.acc),
        .q   (rnd)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pv   = vld;
        st_d.pp   = mul_prod;
        st_d.povf = mul_ovf;
        if (add_en) begin
            st_d.acc = sum;
            st_d.sat = st_q.sat | sum_ovf | add_povf;
        end
        if (clr) begin
            st_d.acc = acc_t'(clr_val);
            st_d.sat = 1'b0;
            st_d.pv  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign acc     = st_q.acc;
    assign sat     = st_q.sat;
    assign res_q15 = rnd;

    // R8: a clear loads the given value and drops the flag
    p_clear_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == $past(clr_val)) && !sat);
    // R5: the clamp flag holds until a clear
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sat && !clr) |=> sat);
    // R4: two non-negative terms never produce a negative sum
    p_pos_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && add_en && !acc[ACC_W-1] && !addend[ACC_W-1]) |=> !acc[ACC_W-1]);
    // R4: two negative terms never produce a non-negative sum
    p_neg_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && add_en && acc[ACC_W-1] && addend[ACC_W-1]) |=> acc[ACC_W-1]);
    // R11: with nothing completing, the state holds
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !add_en) |=> ($stable(acc) && $stable(sat)));
    // R7: the rounded view caps at the largest Q0.15 value
    p_round_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc[ACC_W-1 -: OP_W] == 16'h7FFF) |-> (res_q15 == 16'h7FFF));
endmodule

// File: tb/frac_mac_sat_bench.sv
module frac_mac_sat_bench;
    localparam int LAT = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic [31:0] clr_val = '0;
    logic        vld = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic [31:0] acc;
    logic [15:0] res_q15;
    logic        sat;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_acc = '0;
    logic        m_sat = 1'b0;
    logic        m_pv = 1'b0;
    logic [31:0] m_pp = '0;
    logic        m_povf = 1'b0;

    frac_mac_sat #(.PIPE(LAT)) u_frac_mac_sat (
        .clk(clk), .rst_n(rst_n), .clr(clr), .clr_val(clr_val),
        .vld(vld), .op_a(op_a), .op_b(op_b),
        .acc(acc), .res_q15(res_q15), .sat(sat)
    );

    always #10 clk = ~clk;

    function automatic logic [32:0] ref_prod(input logic [15:0] a, input logic [15:0] b);
        longint p;
        if (a == 16'h8000 && b == 16'h8000) return {1'b1, 32'h7FFFFFFF};
        p = longint'($signed(a)) * longint'($signed(b)) * 2;
        return {1'b0, p[31:0]};
    endfunction

    function automatic logic [32:0] ref_add(input logic [31:0] x, input logic [31:0] y);
        longint s;
        s = longint'($signed(x)) + longint'($signed(y));
        if (s > 64'sd2147483647) return {1'b1, 32'h7FFFFFFF};
        if (s < -64'sd2147483648) return {1'b1, 32'h80000000};
        return {1'b0, s[31:0]};
    endfunction

    function automatic logic [15:0] ref_round(input logic [31:0] x);
        if (x[31:16] == 16'h7FFF && x[15]) return 16'h7FFF;
        return x[31:16] + {15'd0, x[15]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic model_add(input logic [31:0] p, input logic povf);
        logic [32:0] r;
        r = ref_add(m_acc, p);
        m_acc = r[31:0];
        m_sat = m_sat | r[32] | povf;
    endtask

    task automatic step(input logic c, input logic [31:0] cv, input logic v,
                        input logic [15:0] a, input logic [15:0] b);
        logic [32:0] pr;
        clr = c; clr_val = cv; vld = v; op_a = a; op_b = b;
        @(posedge clk);
        pr = ref_prod(a, b);
        if (c) begin
            m_acc = cv; m_sat = 1'b0; m_pv = 1'b0;
        end else if (LAT != 0) begin
            if (m_pv) model_add(m_pp, m_povf);
            m_pv = v; m_pp = pr[31:0]; m_povf = pr[32];
        end else if (v) begin
            model_add(pr[31:0], pr[32]);
        end
        @(negedge clk);
        chk("R3/R4 acc", acc, m_acc);
        chk("R5 sat", {31'd0, sat}, {31'd0, m_sat});
        chk("R7 res_q15", {16'd0, res_q15}, {16'd0, ref_round(m_acc)});
    endtask

    function automatic logic [15:0] pick_op();
        int s = $urandom_range(0, 9);
        case (s)
            0: return 16'h8000;
            1: return 16'h7FFF;
            2: return 16'h7FFF - 16'($urandom_range(0, 3));
            3: return 16'h8000 + 16'($urandom_range(0, 3));
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 acc", acc, 32'h0);
        chk("R1 res", {16'd0, res_q15}, 32'h0);
        chk("R1 sat", {31'd0, sat}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: latency, R2: product alignment
        step(1'b0, 32'h0, 1'b1, 16'h4000, 16'h4000);
        if (LAT != 0) chk("R9 no change yet", acc, 32'h0);
        step(1'b0, 32'h0, 1'b0, 16'h0, 16'h0);
        chk("R2 0.5*0.5", acc, 32'h20000000);
        // R11: idle holds
        step(1'b0, 32'h0, 1'b0, 16'h1234, 16'h5678);
        chk("R11 idle hold", acc, 32'h20000000);

        // R6: -1 * -1
        step(1'b1, 32'h0, 1'b0, 16'h0, 16'h0);
        step(1'b0, 32'h0, 1'b1, 16'h8000, 16'h8000);
        step(1'b0, 32'h0, 1'b0, 16'h0, 16'h0);
        chk("R6 acc", acc, 32'h7FFFFFFF);
        chk("R6 sat", {31'd0, sat}, 32'h1);
        chk("R7 cap", {16'd0, res_q15}, 32'h7FFF);

        // R8: clear beats strobe and drops in-flight op
        step(1'b0, 32'h0, 1'b1, 16'h4000, 16'h4000);
        step(1'b1, 32'h00010000, 1'b1, 16'h4000, 16'h4000);
        step(1'b0, 32'h0, 1'b0, 16'h0, 16'h0);
        chk("R8 clear value", acc, 32'h00010000);
        chk("R8 sat cleared", {31'd0, sat}, 32'h0);

        // R4: negative clamp
        step(1'b1, 32'h80000010, 1'b0, 16'h0, 16'h0);
        step(1'b0, 32'h0, 1'b1, 16'h8000, 16'h7FFF);
        step(1'b0, 32'h0, 1'b0, 16'h0, 16'h0);
        chk("R4 neg clamp", acc, 32'h80000000);
        // R5: sticky across idle
        step(1'b0, 32'h0, 1'b0, 16'h0, 16'h0);
        chk("R5 sticky", {31'd0, sat}, 32'h1);

        // R10: back-to-back strobes
        step(1'b1, 32'h0, 1'b0, 16'h0, 16'h0);
        for (int i = 0; i < 4; i++) step(1'b0, 32'h0, 1'b1, 16'h0800, 16'h0100);
        step(1'b0, 32'h0, 1'b0, 16'h0, 16'h0);
        chk("R10 four in a row", acc, 32'h00400000);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic c = ($urandom_range(0, 39) == 0);
            step(c, $urandom, ($urandom_range(0, 3) != 0), pick_op(), pick_op());
        end
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule